// File: doc/BRIEF.md
# Three-Register ALU Operand Router

This block sits in front of an external ALU and owns three W-bit working registers, named A, B and C. A 3-bit routing code picks which register feeds the ALU's x operand, which feeds its y operand, and which register receives the result. The eight codes form a fixed map. It includes two unary in-place codes and one code where a source register is also the destination, so that a value can be accumulated repeatedly.

Each operation runs in two phases. In the capture phase the selected operands are presented on `x_o` and `y_o`, and the ALU result is taken into an internal latch at the end of that cycle. In the writeback phase the latch is copied into the destination register. Since the operands are no longer needed by then, a register can be both source and destination. The registers can be loaded through a dedicated load port while the block is idle.

Top module: `alu_route_top`

## Requirements
- R1: After reset all three registers read zero, `x_o` and `y_o` are zero, and `busy_o` and `done_o` are low.
- R2: While idle, `ld_en_i` bit 0 loads A, bit 1 loads B and bit 2 loads C from `ld_data_i` at the next clock edge.
- R3: The routing code maps as (x, y → destination): 000 A,none→A; 001 A,B→C; 010 A,C→B; 011 none,B→B; 100 B,A→C; 101 B,C→A; 110 C,A→C; 111 C,B→A.
- R4: `x_o` and `y_o` are zero outside the capture phase, and an operand marked none reads zero during the capture phase.
- R5: A `start_i` seen while idle makes the next cycle the capture phase, with `busy_o` high. `alu_res_i` is sampled at the end of that cycle, the destination is written at the end of the following cycle, and `done_o` is high for exactly the one cycle after that write.
- R6: Registers do not change during the capture phase, and an operation changes only its destination register.
- R7: When the destination is also a source, it receives the result computed from its old value.
- R8: `start_i` is ignored while `busy_o` is high. Holding it through an operation does not queue a second one.
- R9: Load requests are ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| route_i | input | 3 | Routing code, sampled with start |
| start_i | input | 1 | Begin an operation |
| alu_res_i | input | W | Result from the external ALU |
| ld_en_i | input | 3 | Per-register load enables (bit 0 A, 1 B, 2 C) |
| ld_data_i | input | W | Load data |
| x_o | output | W | ALU operand x |
| y_o | output | W | ALU operand y |
| reg_a_o | output | W | Register A contents |
| reg_b_o | output | W | Register B contents |
| reg_c_o | output | W | Register C contents |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse after writeback |

## Verification
The assertions assume that `alu_res_i` is a combinational function of `x_o` and `y_o` that settles within the capture cycle. They also assume that loads and starts may arrive in any phase and must be absorbed. The bench models the ALU as x + y + k with a settable k, and changes k only between operations. It deliberately holds `start_i` and raises every load enable during busy phases, to confirm that such requests leave no trace.

// File: rtl/alu_route_pkg.sv
package alu_route_pkg;
  typedef enum logic [1:0] {SEL_A = 2'd0, SEL_B = 2'd1, SEL_C = 2'd2, SEL_NONE = 2'd3} reg_sel_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_CAPT = 2'd1, ST_WB = 2'd2} seq_state_e;

  typedef struct packed {
    reg_sel_e src_x;
    reg_sel_e src_y;
    reg_sel_e dst;
  } route_t;

  function automatic route_t route_map(input logic [2:0] code);
    route_t r;
    case (code)
      3'b000:  r = '{SEL_A, SEL_NONE, SEL_A};
      3'b001:  r = '{SEL_A, SEL_B, SEL_C};
      3'b010:  r = '{SEL_A, SEL_C, SEL_B};
      3'b011:  r = '{SEL_NONE, SEL_B, SEL_B};
      3'b100:  r = '{SEL_B, SEL_A, SEL_C};
      3'b101:  r = '{SEL_B, SEL_C, SEL_A};
      3'b110:  r = '{SEL_C, SEL_A, SEL_C};
      default: r = '{SEL_C, SEL_B, SEL_A};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/route_seq.sv
module route_seq
  import alu_route_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CODE_W-1:0] route_i,
  output logic [CODE_W-1:0] route_o,
  output logic              capt_o,
  output logic              wb_o,
  output logic              busy_o,
  output logic              done_o
);
  seq_state_e state_q, state_d;
  logic [CODE_W-1:0] route_q;
  logic done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_CAPT;
      ST_CAPT: state_d = ST_WB;
      ST_WB:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      route_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_WB);
      if (state_q == ST_IDLE && start_i) route_q <= route_i;
    end
  end

  assign route_o = route_q;
  assign capt_o  = (state_q == ST_CAPT);
  assign wb_o    = (state_q == ST_WB);
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;

  // R5: capture is always followed by writeback, then a done pulse
  p_capt_then_wb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CAPT) |=> (state_q == ST_WB));
  p_done_after_wb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WB) |=> (done_o && !busy_o));
  // R8: route held while busy
  p_route_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(route_q));
endmodule

// File: rtl/route_regfile.sv
module route_regfile #(
  parameter int W      = 10,
  parameter int N_REGS = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_REGS-1:0]      ld_en_i,
  input  logic [W-1:0]           ld_data_i,
  input  logic [N_REGS-1:0]      wb_en_i,
  input  logic [W-1:0]           wb_data_i,
  output logic [N_REGS-1:0][W-1:0] regs_o
);
  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         q <= '0;
      else if (wb_en_i[g]) q <= wb_data_i;
      else if (ld_en_i[g]) q <= ld_data_i;
    end
    assign regs_o[g] = q;
  end

  // R6: a single destination per writeback
  p_one_dst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wb_en_i));
  // R9: loads never coincide with a writeback
  p_no_ld_in_wb_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_en_i != '0) |-> (ld_en_i == '0));
endmodule

// File: rtl/alu_route_top.sv
module alu_route_top
  import alu_route_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [2:0]   route_i,
  input  logic         start_i,
  input  logic [W-1:0] alu_res_i,
  input  logic [2:0]   ld_en_i,
  input  logic [W-1:0] ld_data_i,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o,
  output logic [W-1:0] reg_a_o,
  output logic [W-1:0] reg_b_o,
  output logic [W-1:0] reg_c_o,
  output logic         busy_o,
  output logic         done_o
);
  localparam int N_REGS = 3;
  localparam int CODE_W = 3;

  logic [CODE_W-1:0] route_q;
  logic capt, wb, busy;
  logic [W-1:0] res_q;
  logic [N_REGS-1:0][W-1:0] regs;
  logic [N_REGS-1:0] wb_en, ld_en;
  route_t rt;

  route_seq #(.CODE_W(CODE_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .route_i,
    .route_o(route_q), .capt_o(capt), .wb_o(wb), .busy_o(busy), .done_o
  );

  assign rt = route_map(route_q);

  function automatic logic [W-1:0] pick(input reg_sel_e s, input logic [N_REGS-1:0][W-1:0] r);
    case (s)
      SEL_A:   return r[0];
      SEL_B:   return r[1];
      SEL_C:   return r[2];
      default: return '0;
    endcase
  endfunction

  assign x_o = capt ? pick(rt.src_x, regs) : '0;
  assign y_o = capt ? pick(rt.src_y, regs) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   res_q <= '0;
    else if (capt) res_q <= alu_res_i;
  end

  always_comb begin
    wb_en = '0;
    if (wb && rt.dst != SEL_NONE) wb_en[rt.dst] = 1'b1;
  end
  assign ld_en = busy ? '0 : ld_en_i;

  route_regfile #(.W(W), .N_REGS(N_REGS)) u_rf (
    .clk_i, .rst_ni, .ld_en_i(ld_en), .ld_data_i,
    .wb_en_i(wb_en), .wb_data_i(res_q), .regs_o(regs)
  );

  assign reg_a_o = regs[0];
  assign reg_b_o = regs[1];
  assign reg_c_o = regs[2];
  assign busy_o  = busy;

  // R6: sources hold while operands are presented
  p_src_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capt |=> $stable(regs));
  // R4: operands zero outside capture
  p_idle_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capt |-> (x_o == '0 && y_o == '0));
  // R7: destination receives the value captured one cycle earlier
  p_wb_value_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capt |=> ##1 (regs[rt.dst] == $past(alu_res_i, 2)));
endmodule

// File: tb/sim_alu_route_top.sv
module sim_alu_route_top;
  localparam int W = 10;
  localparam int MASK = (1 << W) - 1;

  logic clk = 0, rst_n = 0;
  logic [2:0] route = 0, ld_en = 0;
  logic start = 0;
  logic [W-1:0] ld_data = 0, alu_res, x, y, ra, rb, rc;
  logic busy, done;
  int k_add = 0;
  int checks = 0, fails = 0;
  int mdl[3];

  always #5 clk = ~clk;

  assign alu_res = W'((int'(x) + int'(y) + k_add) & MASK);

  alu_route_top #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .route_i(route), .start_i(start),
    .alu_res_i(alu_res), .ld_en_i(ld_en), .ld_data_i(ld_data),
    .x_o(x), .y_o(y), .reg_a_o(ra), .reg_b_o(rb), .reg_c_o(rc),
    .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rdreg(input int i);
    return (i == 0) ? int'(ra) : (i == 1) ? int'(rb) : int'(rc);
  endfunction

  task automatic chk_regs(input string req);
    for (int i = 0; i < 3; i++) chk(req, rdreg(i), mdl[i]);
  endtask

  // routing per R3: -1 means none
  task automatic route_of(input int code, output int xi, output int yi, output int di);
    case (code)
      0: begin xi = 0;  yi = -1; di = 0; end
      1: begin xi = 0;  yi = 1;  di = 2; end
      2: begin xi = 0;  yi = 2;  di = 1; end
      3: begin xi = -1; yi = 1;  di = 1; end
      4: begin xi = 1;  yi = 0;  di = 2; end
      5: begin xi = 1;  yi = 2;  di = 0; end
      6: begin xi = 2;  yi = 0;  di = 2; end
      default: begin xi = 2; yi = 1; di = 0; end
    endcase
  endtask

  task automatic load(input int i, input int v);
    @(negedge clk);
    ld_en = 3'(1 << i); ld_data = W'(v);
    @(negedge clk);
    ld_en = 0;
    mdl[i] = v & MASK;
    chk("R2", rdreg(i), mdl[i]);
  endtask

  task automatic run_op(input int code, input int k, input bit hold_noise);
    int xi, yi, di, xv, yv, res;
    route_of(code, xi, yi, di);
    xv = (xi < 0) ? 0 : mdl[xi];
    yv = (yi < 0) ? 0 : mdl[yi];
    res = (xv + yv + k) & MASK;
    @(negedge clk);
    k_add = k; route = 3'(code); start = 1;
    @(negedge clk);            // capture phase
    chk("R5", int'(busy), 1);
    chk("R3", int'(x), xv);
    chk("R3", int'(y), yv);
    if (hold_noise) begin
      route = 3'(code ^ 3'b111); ld_en = 3'b111; ld_data = '1;
    end else start = 0;
    @(negedge clk);            // writeback phase
    chk_regs("R6");
    chk("R4", int'(x), 0);
    chk("R4", int'(y), 0);
    chk("R5", int'(done), 0);
    start = 0; ld_en = 0;
    @(negedge clk);            // written
    mdl[di] = res;
    chk("R5", int'(done), 1);
    chk_regs(hold_noise ? "R9" : "R7");
    @(negedge clk);
    chk("R8", int'(busy), 0);
    chk("R5", int'(done), 0);
    chk_regs("R6");
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) mdl[i] = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_regs("R1");
    chk("R1", int'(busy), 0);
    chk("R1", int'(done), 0);
    chk("R1", int'(x), 0);
    chk("R1", int'(y), 0);
    load(0, 5); load(1, 100); load(2, 1000);
    for (int c = 0; c < 8; c++) run_op(c, c, 1'b0);
    run_op(0, 1, 1'b0);        // in-place increment of A
    run_op(3, MASK, 1'b0);     // in-place decrement of B
    for (int n = 0; n < 3; n++) run_op(6, 0, 1'b0); // accumulate C += A
    run_op(1, 0, 1'b1);        // start and loads held during busy
    run_op(7, 3, 1'b1);
    load(2, MASK);
    run_op(6, 0, 1'b0);        // wrap around
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule